// File: doc/BRIEF.md
# Flash block access protection unit

This unit guards the program flash of a small controller. Every access arrives from one of two places: the processor's internal table-read/table-write path or an external programming port. Each access carries a target address, the program counter of the instruction that issued it, a type (read, write, full erase, block erase) and write data. The unit decides in the same cycle whether the access may reach the flash array. A refused read returns zero data and a status flag. A refused write keeps the array's write strobe low and raises a violation pulse one cycle later.

User program memory is split into three regions: a boot region, a low region and a high region. Each region has three protection bits. The first gates writes from the internal table path. The second gates internal table reads that come from code running outside the region. The third gates every access from the external port. Separate bits cover the data EEPROM and the configuration area. All protection bits sit in six byte-wide configuration registers that the internal path can read and write. A write can only clear these bits. Only an erase command from the external port sets them back to one. Two device identification bytes are readable through the same path.

Top module: `flash_guard`

## Requirements
- R1: Region decode uses parameterised upper bounds. Addresses up to 0x0007FF are the boot region, up to 0x003FFF the low region, and up to 0x007FFF the high region. Addresses above that are outside all regions, and no protection bit applies to them.
- R2: An internal write (`req_src`=0, `req_op`=01) to a region whose internal-write bit is 0 keeps `flash_we` low, whatever the program counter is. `wr_violation` is then high for exactly the following cycle. Any refused write produces the same pulse.
- R3: An internal read (`req_op`=00) of a region whose internal-read bit is 0 is granted only when `req_pc` decodes to that same region. When refused, `rd_data` is 0, `rd_denied` is 1 and `flash_re` is 0. When granted, `rd_data` equals `flash_rdata` and `flash_re` is 1.
- R4: The external-access bits do not affect internal accesses. For `req_src`=1, reads and writes of a region are allowed exactly when that region's external-access bit is 1, and the internal-write and internal-read bits are then ignored.
- R5: A permitted write to a protection byte stores old AND data in each implemented bit. Layout by address: 0x300008 has high-region external bit at bit 1 and low-region external bit at bit 0. 0x300009 has EEPROM external bit at 7 and boot external bit at 6. 0x30000A has high and low internal-write bits at 1 and 0. 0x30000B has EEPROM write bit at 7, boot internal-write at 6 and configuration write bit at 5. 0x30000C has high and low internal-read bits at 1 and 0. 0x30000D has boot internal-read bit at 6.
- R6: An external full erase (`req_op`=10) sets every protection bit to 1. An external block erase (`req_op`=11) sets the three bits of the region that `req_addr` decodes to. Erase requests from the internal path change nothing.
- R7: Protection bytes read back through the internal path, with unimplemented bits reading 0. When the configuration write bit is 0, internal writes to the protection bytes are refused. External writes to them remain allowed.
- R8: Reads of 0x3FFFFE and 0x3FFFFF return the low and high identification bytes. Writes to either address are refused.
- R9: After reset every protection bit equals the preload parameter, whose default is all ones. With no request, `flash_re`, `flash_we`, `rd_denied`, `rd_data` and `wr_violation` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Access request present this cycle |
| req_src | input | 1 | 0 internal table path, 1 external programming port |
| req_op | input | 2 | 00 read, 01 write, 10 full erase, 11 block erase |
| req_addr | input | ADDR_W | Target address |
| req_pc | input | ADDR_W | Program counter of the issuing instruction |
| req_wdata | input | 8 | Write data |
| flash_rdata | input | 8 | Read data returned by the flash array |
| flash_re | output | 1 | Read strobe to the flash array |
| flash_we | output | 1 | Write strobe to the flash array |
| rd_data | output | 8 | Read data to the requester, zero when refused |
| rd_denied | output | 1 | The current read was refused |
| wr_violation | output | 1 | One-cycle pulse after a refused write |

## Verification
The hardest situation to reach is a read whose outcome depends on the issuing program counter. A region's internal-read bit can only be cleared through an earlier protection-byte write. After that, the same target has to be read from code inside the region, from code in a neighbouring region and from code exactly at a boundary. The stimulus table builds this state step by step and crosses those counter positions. It then interleaves external accesses, internal and external erases and a lock of the configuration bytes themselves. Each clear or restore is read back through the protection bytes.

// File: rtl/fg_pkg.sv
`timescale 1ns/1ps
package fg_pkg;

  typedef enum logic [1:0] {
    OP_READ      = 2'b00,
    OP_WRITE     = 2'b01,
    OP_ERASE_ALL = 2'b10,
    OP_ERASE_BLK = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    RG_BOOT = 2'd0,
    RG_LOW  = 2'd1,
    RG_HIGH = 2'd2,
    RG_OPEN = 2'd3
  } region_e;

  localparam int NUM_BLK   = 3;
  localparam int CFG_BYTES = 6;
  localparam int PROT_W    = 3 * NUM_BLK + 3;

  // a bit value of 1 means the matching access is allowed
  typedef struct packed {
    logic               cfg_wr_ok;
    logic               ee_wr_ok;
    logic               ee_ext_ok;
    logic [NUM_BLK-1:0] tr_ok;
    logic [NUM_BLK-1:0] tw_ok;
    logic [NUM_BLK-1:0] ext_ok;
  } prot_t;

  function automatic logic [7:0] cfg_byte(input prot_t p, input logic [2:0] ofs);
    logic [7:0] b;
    b = 8'h00;
    case (ofs)
      3'd0: b = {6'b0, p.ext_ok[2], p.ext_ok[1]};
      3'd1: b = {p.ee_ext_ok, p.ext_ok[0], 6'b0};
      3'd2: b = {6'b0, p.tw_ok[2], p.tw_ok[1]};
      3'd3: b = {p.ee_wr_ok, p.tw_ok[0], p.cfg_wr_ok, 5'b0};
      3'd4: b = {6'b0, p.tr_ok[2], p.tr_ok[1]};
      3'd5: b = {1'b0, p.tr_ok[0], 6'b0};
      default: b = 8'h00;
    endcase
    return b;
  endfunction

  function automatic prot_t cfg_clear(input prot_t p, input logic [2:0] ofs,
                                      input logic [7:0] d);
    prot_t q;
    q = p;
    case (ofs)
      3'd0: begin
        q.ext_ok[1] = p.ext_ok[1] & d[0];
        q.ext_ok[2] = p.ext_ok[2] & d[1];
      end
      3'd1: begin
        q.ext_ok[0] = p.ext_ok[0] & d[6];
        q.ee_ext_ok = p.ee_ext_ok & d[7];
      end
      3'd2: begin
        q.tw_ok[1] = p.tw_ok[1] & d[0];
        q.tw_ok[2] = p.tw_ok[2] & d[1];
      end
      3'd3: begin
        q.cfg_wr_ok = p.cfg_wr_ok & d[5];
        q.tw_ok[0]  = p.tw_ok[0] & d[6];
        q.ee_wr_ok  = p.ee_wr_ok & d[7];
      end
      3'd4: begin
        q.tr_ok[1] = p.tr_ok[1] & d[0];
        q.tr_ok[2] = p.tr_ok[2] & d[1];
      end
      3'd5: q.tr_ok[0] = p.tr_ok[0] & d[6];
      default: q = p;
    endcase
    return q;
  endfunction

endpackage

// File: rtl/fg_region_dec.sv
`timescale 1ns/1ps
module fg_region_dec
  import fg_pkg::*;
#(
  parameter int              ADDR_W   = 22,
  parameter logic [ADDR_W-1:0] BOOT_END = 22'h0007FF,
  parameter logic [ADDR_W-1:0] LOW_END  = 22'h003FFF,
  parameter logic [ADDR_W-1:0] HIGH_END = 22'h007FFF
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           rg
);

  always_comb begin
    if (addr <= BOOT_END)      rg = RG_BOOT;
    else if (addr <= LOW_END)  rg = RG_LOW;
    else if (addr <= HIGH_END) rg = RG_HIGH;
    else                       rg = RG_OPEN;
  end

endmodule

// File: rtl/fg_space_dec.sv
`timescale 1ns/1ps
module fg_space_dec
  import fg_pkg::*;
#(
  parameter int                ADDR_W   = 22,
  parameter logic [ADDR_W-1:0] CFG_BASE = 22'h300008,
  parameter logic [ADDR_W-1:0] ID_BASE  = 22'h3FFFFE
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_cfg,
  output logic [2:0]        cfg_ofs,
  output logic              is_id,
  output logic              id_hi
);

  localparam logic [ADDR_W-1:0] CFG_LAST = CFG_BASE + ADDR_W'(CFG_BYTES - 1);

  always_comb begin
    is_cfg  = (addr >= CFG_BASE) && (addr <= CFG_LAST);
    cfg_ofs = addr[2:0] - CFG_BASE[2:0];
    is_id   = (addr[ADDR_W-1:1] == ID_BASE[ADDR_W-1:1]);
    id_hi   = addr[0];
  end

endmodule

// File: rtl/fg_prot_store.sv
`timescale 1ns/1ps
module fg_prot_store
  import fg_pkg::*;
#(
  parameter logic [PROT_W-1:0] PROT_INIT = '1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [2:0] cfg_ofs,
  input  logic [7:0] cfg_wdata,
  input  logic       erase_all,
  input  logic       erase_blk,
  input  region_e    erase_rg,
  output prot_t      prot_q
);

  prot_t prot_d;
  logic  prot_en;

  assign prot_en = erase_all | erase_blk | cfg_we;

  always_comb begin
    prot_d = prot_q;
    if (erase_all) begin
      prot_d = '1;
    end else if (erase_blk) begin
      for (int b = 0; b < NUM_BLK; b++) begin
        if (erase_rg == region_e'(b)) begin
          prot_d.ext_ok[b] = 1'b1;
          prot_d.tw_ok[b]  = 1'b1;
          prot_d.tr_ok[b]  = 1'b1;
        end
      end
    end else if (cfg_we) begin
      prot_d = cfg_clear(prot_q, cfg_ofs, cfg_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prot_q <= prot_t'(PROT_INIT);
    else if (prot_en) prot_q <= prot_d;
  end

endmodule

// File: rtl/fg_access_ctl.sv
`timescale 1ns/1ps
module fg_access_ctl
  import fg_pkg::*;
(
  input  logic    req_valid,
  input  logic    req_src,
  input  op_e     req_op,
  input  region_e tgt_rg,
  input  region_e pc_rg,
  input  logic    tgt_cfg,
  input  logic    tgt_id,
  input  prot_t   prot,
  output logic    rd_grant,
  output logic    wr_grant,
  output logic    wr_deny,
  output logic    rd_deny,
  output logic    erase_all,
  output logic    erase_blk
);

  logic is_rd, is_wr, user, rd_allow, wr_allow;

  assign is_rd = req_valid && (req_op == OP_READ);
  assign is_wr = req_valid && (req_op == OP_WRITE);
  assign user  = !tgt_cfg && !tgt_id && (tgt_rg != RG_OPEN);

  always_comb begin
    rd_allow = 1'b1;
    wr_allow = 1'b1;
    if (tgt_id) begin
      wr_allow = 1'b0;
    end else if (tgt_cfg) begin
      wr_allow = req_src || prot.cfg_wr_ok;
    end
    for (int b = 0; b < NUM_BLK; b++) begin
      if (user && (tgt_rg == region_e'(b))) begin
        if (req_src) begin
          rd_allow = prot.ext_ok[b];
          wr_allow = prot.ext_ok[b];
        end else begin
          rd_allow = prot.tr_ok[b] || (pc_rg == tgt_rg);
          wr_allow = prot.tw_ok[b];
        end
      end
    end
  end

  assign rd_grant  = is_rd && rd_allow;
  assign rd_deny   = is_rd && !rd_allow;
  assign wr_grant  = is_wr && wr_allow;
  assign wr_deny   = is_wr && !wr_allow;
  assign erase_all = req_valid && req_src && (req_op == OP_ERASE_ALL);
  assign erase_blk = req_valid && req_src && (req_op == OP_ERASE_BLK);

endmodule

// File: rtl/flash_guard.sv
`timescale 1ns/1ps
module flash_guard
  import fg_pkg::*;
#(
  parameter int                ADDR_W    = 22,
  parameter logic [ADDR_W-1:0] BOOT_END  = 22'h0007FF,
  parameter logic [ADDR_W-1:0] LOW_END   = 22'h003FFF,
  parameter logic [ADDR_W-1:0] HIGH_END  = 22'h007FFF,
  parameter logic [ADDR_W-1:0] CFG_BASE  = 22'h300008,
  parameter logic [ADDR_W-1:0] ID_BASE   = 22'h3FFFFE,
  parameter logic [7:0]        ID_LO     = 8'hC3,
  parameter logic [7:0]        ID_HI     = 8'h1E,
  parameter logic [PROT_W-1:0] PROT_INIT = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_src,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_pc,
  input  logic [7:0]        req_wdata,
  input  logic [7:0]        flash_rdata,
  output logic              flash_re,
  output logic              flash_we,
  output logic [7:0]        rd_data,
  output logic              rd_denied,
  output logic              wr_violation
);

  localparam int NDEC = 2;

  logic              rst_meta_n, rst_sync_n;
  logic [ADDR_W-1:0] dec_addr [NDEC];
  region_e           dec_rg   [NDEC];
  logic              tgt_cfg, tgt_id, id_hi;
  logic [2:0]        cfg_ofs;
  prot_t             prot_q;
  logic              rd_grant, wr_grant, wr_deny, rd_deny;
  logic              erase_all, erase_blk, cfg_we;
  logic              viol_d, viol_q;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign dec_addr[0] = req_addr;
  assign dec_addr[1] = req_pc;

  for (genvar i = 0; i < NDEC; i++) begin : g_dec
    fg_region_dec #(
      .ADDR_W  (ADDR_W),
      .BOOT_END(BOOT_END),
      .LOW_END (LOW_END),
      .HIGH_END(HIGH_END)
    ) u_rdec (
      .addr(dec_addr[i]),
      .rg  (dec_rg[i])
    );
  end

  fg_space_dec #(
    .ADDR_W  (ADDR_W),
    .CFG_BASE(CFG_BASE),
    .ID_BASE (ID_BASE)
  ) u_sdec (
    .addr   (req_addr),
    .is_cfg (tgt_cfg),
    .cfg_ofs(cfg_ofs),
    .is_id  (tgt_id),
    .id_hi  (id_hi)
  );

  fg_access_ctl u_ctl (
    .req_valid(req_valid),
    .req_src  (req_src),
    .req_op   (op_e'(req_op)),
    .tgt_rg   (dec_rg[0]),
    .pc_rg    (dec_rg[1]),
    .tgt_cfg  (tgt_cfg),
    .tgt_id   (tgt_id),
    .prot     (prot_q),
    .rd_grant (rd_grant),
    .wr_grant (wr_grant),
    .wr_deny  (wr_deny),
    .rd_deny  (rd_deny),
    .erase_all(erase_all),
    .erase_blk(erase_blk)
  );

  assign cfg_we = wr_grant && tgt_cfg;

  fg_prot_store #(
    .PROT_INIT(PROT_INIT)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cfg_we   (cfg_we),
    .cfg_ofs  (cfg_ofs),
    .cfg_wdata(req_wdata),
    .erase_all(erase_all),
    .erase_blk(erase_blk),
    .erase_rg (dec_rg[0]),
    .prot_q   (prot_q)
  );

  always_comb begin
    rd_data = 8'h00;
    if (rd_grant) begin
      if (tgt_cfg)     rd_data = cfg_byte(prot_q, cfg_ofs);
      else if (tgt_id) rd_data = id_hi ? ID_HI : ID_LO;
      else             rd_data = flash_rdata;
    end
  end

  assign flash_re  = rd_grant && !tgt_cfg && !tgt_id;
  assign flash_we  = wr_grant && !tgt_cfg && !tgt_id;
  assign rd_denied = rd_deny;

  assign viol_d = wr_deny;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) viol_q <= 1'b0;
    else             viol_q <= viol_d;
  end

  assign wr_violation = viol_q;

endmodule

// File: rtl/fg_guard_chk.sv
`timescale 1ns/1ps
module fg_guard_chk
  import fg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_src,
  input logic [1:0] req_op,
  input region_e    tgt_rg,
  input logic       tgt_cfg,
  input logic       tgt_id,
  input prot_t      prot,
  input logic       flash_re,
  input logic       flash_we,
  input logic [7:0] rd_data,
  input logic       rd_denied,
  input logic       wr_violation
);

  logic tw_lock, ext_lock;

  always_comb begin
    tw_lock  = 1'b0;
    ext_lock = 1'b0;
    for (int b = 0; b < NUM_BLK; b++) begin
      if (!tgt_cfg && !tgt_id && (tgt_rg == region_e'(b))) begin
        tw_lock  = !prot.tw_ok[b];
        ext_lock = !prot.ext_ok[b];
      end
    end
  end

  AST_LOCKED_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_src && req_op == 2'b01 && tw_lock) |-> !flash_we); // R2

  AST_LOCKED_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_src && req_op == 2'b01 && tw_lock) |=> wr_violation); // R2

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_violation |-> $past(req_valid && req_op == 2'b01)); // R2

  AST_DENY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_denied |-> (rd_data == 8'h00 && !flash_re)); // R3

  AST_EXT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_src && req_op[1] == 1'b0 && ext_lock) |-> (!flash_we && !flash_re)); // R4

  AST_ONLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_src && req_op[1]) |=> ((prot & ~$past(prot)) == '0)); // R5

  AST_INT_ERASE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_src && req_op[1]) |=> $stable(prot)); // R6

endmodule

bind flash_guard fg_guard_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_src     (req_src),
  .req_op      (req_op),
  .tgt_rg      (dec_rg[0]),
  .tgt_cfg     (tgt_cfg),
  .tgt_id      (tgt_id),
  .prot        (prot_q),
  .flash_re    (flash_re),
  .flash_we    (flash_we),
  .rd_data     (rd_data),
  .rd_denied   (rd_denied),
  .wr_violation(wr_violation)
);

// File: tb/flash_guard_test.sv
`timescale 1ns/1ps
module flash_guard_test;

  localparam logic [1:0] RD = 2'b00, WR = 2'b01, CE = 2'b10, BE = 2'b11;
  localparam logic [21:0] KB = 22'h000100, K0 = 22'h001000, K1 = 22'h005000;

  typedef struct packed {
    logic        src;
    logic [1:0]  op;
    logic [21:0] addr;
    logic [21:0] pc;
    logic [7:0]  wd;
    logic [7:0]  fd;
    logic        re;
    logic        we;
    logic        dn;
    logic [7:0]  dat;
    logic        vi;
    logic [3:0]  req;
  } vec_t;

  function automatic vec_t mk(input logic s, input logic [1:0] o, input logic [21:0] a,
                              input logic [21:0] p, input logic [7:0] w, input logic [7:0] f,
                              input logic re, input logic we, input logic dn,
                              input logic [7:0] d, input logic vi, input logic [3:0] rq);
    return '{src:s, op:o, addr:a, pc:p, wd:w, fd:f, re:re, we:we, dn:dn, dat:d, vi:vi, req:rq};
  endfunction

  localparam int NV = 58;
  localparam vec_t VT [NV] = '{
    mk(0,RD,K0,K1,8'h00,8'hA5,1,0,0,8'hA5,0,3),            // R3 open read
    mk(0,RD,22'h300008,KB,8'h00,8'h77,0,0,0,8'h03,0,7),    // R7 reset layout
    mk(0,RD,22'h300009,KB,8'h00,8'h77,0,0,0,8'hC0,0,7),
    mk(0,RD,22'h30000A,KB,8'h00,8'h77,0,0,0,8'h03,0,7),
    mk(0,RD,22'h30000B,KB,8'h00,8'h77,0,0,0,8'hE0,0,7),
    mk(0,RD,22'h30000C,KB,8'h00,8'h77,0,0,0,8'h03,0,7),
    mk(0,RD,22'h30000D,KB,8'h00,8'h77,0,0,0,8'h40,0,7),
    mk(0,WR,22'h30000A,KB,8'hFE,8'h00,0,0,0,8'h00,0,5),    // R5 clear low write bit
    mk(0,RD,22'h30000A,KB,8'h00,8'h00,0,0,0,8'h02,0,5),
    mk(0,WR,22'h30000A,KB,8'hFF,8'h00,0,0,0,8'h00,0,5),    // R5 ones do not set
    mk(0,RD,22'h30000A,KB,8'h00,8'h00,0,0,0,8'h02,0,5),
    mk(0,WR,K0,K0,8'h11,8'h00,0,0,0,8'h00,1,2),            // R2 pc inside, still blocked
    mk(0,WR,K1,K0,8'h11,8'h00,0,1,0,8'h00,0,2),
    mk(0,WR,KB,K0,8'h11,8'h00,0,1,0,8'h00,0,2),
    mk(0,WR,22'h003FFF,KB,8'h11,8'h00,0,0,0,8'h00,1,1),    // R1 boundaries
    mk(0,WR,22'h004000,KB,8'h11,8'h00,0,1,0,8'h00,0,1),
    mk(0,WR,22'h0007FF,KB,8'h11,8'h00,0,1,0,8'h00,0,1),
    mk(0,WR,22'h000800,KB,8'h11,8'h00,0,0,0,8'h00,1,1),
    mk(0,WR,22'h30000A,KB,8'hFD,8'h00,0,0,0,8'h00,0,5),    // R5
    mk(0,RD,22'h30000A,KB,8'h00,8'h00,0,0,0,8'h00,0,5),
    mk(0,WR,22'h007FFF,KB,8'h11,8'h00,0,0,0,8'h00,1,1),    // R1
    mk(0,WR,22'h008000,KB,8'h11,8'h00,0,1,0,8'h00,0,1),
    mk(0,WR,22'h30000C,KB,8'hFD,8'h00,0,0,0,8'h00,0,5),    // R5 clear high read bit
    mk(0,RD,22'h30000C,KB,8'h00,8'h00,0,0,0,8'h01,0,5),
    mk(0,RD,K1,K0,8'h00,8'h5C,0,0,1,8'h00,0,3),            // R3 foreign pc
    mk(0,RD,K1,22'h004000,8'h00,8'h5C,1,0,0,8'h5C,0,3),    // R3 same region
    mk(0,RD,22'h004000,22'h003FFF,8'h00,8'h5C,0,0,1,8'h00,0,1),
    mk(0,RD,K1,KB,8'h00,8'h5C,0,0,1,8'h00,0,3),
    mk(1,RD,K1,K0,8'h00,8'h5C,1,0,0,8'h5C,0,4),            // R4 external ignores read bit
    mk(0,WR,22'h300008,KB,8'hFE,8'h00,0,0,0,8'h00,0,5),
    mk(0,RD,22'h300008,KB,8'h00,8'h00,0,0,0,8'h02,0,5),
    mk(0,RD,K0,KB,8'h00,8'h3C,1,0,0,8'h3C,0,4),            // R4 internal ignores ext bit
    mk(1,RD,K0,KB,8'h00,8'h3C,0,0,1,8'h00,0,4),
    mk(1,WR,K0,KB,8'h11,8'h00,0,0,0,8'h00,1,4),
    mk(1,WR,K1,KB,8'h11,8'h00,0,1,0,8'h00,0,4),
    mk(0,CE,K0,KB,8'h00,8'h00,0,0,0,8'h00,0,6),            // R6 internal erase ignored
    mk(0,RD,22'h300008,KB,8'h00,8'h00,0,0,0,8'h02,0,6),
    mk(0,BE,K0,KB,8'h00,8'h00,0,0,0,8'h00,0,6),
    mk(0,RD,22'h300008,KB,8'h00,8'h00,0,0,0,8'h02,0,6),
    mk(1,BE,K0,KB,8'h00,8'h00,0,0,0,8'h00,0,6),            // R6 block erase
    mk(0,RD,22'h300008,KB,8'h00,8'h00,0,0,0,8'h03,0,6),
    mk(0,RD,22'h30000A,KB,8'h00,8'h00,0,0,0,8'h01,0,6),
    mk(0,RD,22'h30000C,KB,8'h00,8'h00,0,0,0,8'h01,0,6),
    mk(0,WR,22'h30000B,KB,8'hDF,8'h00,0,0,0,8'h00,0,7),    // R7 lock config
    mk(0,RD,22'h30000B,KB,8'h00,8'h00,0,0,0,8'hC0,0,7),
    mk(0,WR,22'h30000A,KB,8'h00,8'h00,0,0,0,8'h00,1,7),
    mk(0,RD,22'h30000A,KB,8'h00,8'h00,0,0,0,8'h01,0,7),
    mk(1,WR,22'h30000A,KB,8'hFC,8'h00,0,0,0,8'h00,0,7),
    mk(0,RD,22'h30000A,KB,8'h00,8'h00,0,0,0,8'h00,0,7),
    mk(1,CE,K0,KB,8'h00,8'h00,0,0,0,8'h00,0,6),            // R6 full erase
    mk(0,RD,22'h30000A,KB,8'h00,8'h00,0,0,0,8'h03,0,6),
    mk(0,RD,22'h30000B,KB,8'h00,8'h00,0,0,0,8'hE0,0,6),
    mk(0,RD,22'h30000C,KB,8'h00,8'h00,0,0,0,8'h03,0,6),
    mk(0,RD,22'h300008,KB,8'h00,8'h00,0,0,0,8'h03,0,6),
    mk(0,RD,22'h3FFFFE,KB,8'h00,8'h99,0,0,0,8'hC3,0,8),    // R8 id bytes
    mk(0,RD,22'h3FFFFF,KB,8'h00,8'h99,0,0,0,8'h1E,0,8),
    mk(0,WR,22'h3FFFFE,KB,8'h55,8'h00,0,0,0,8'h00,1,8),
    mk(1,RD,22'h3FFFFF,KB,8'h00,8'h99,0,0,0,8'h1E,0,8)
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_src;
  logic [1:0]  req_op;
  logic [21:0] req_addr, req_pc;
  logic [7:0]  req_wdata, flash_rdata;
  logic        flash_re, flash_we, rd_denied, wr_violation;
  logic [7:0]  rd_data;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_guard uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
    .req_op(req_op), .req_addr(req_addr), .req_pc(req_pc), .req_wdata(req_wdata),
    .flash_rdata(flash_rdata), .flash_re(flash_re), .flash_we(flash_we),
    .rd_data(rd_data), .rd_denied(rd_denied), .wr_violation(wr_violation)
  );

  task automatic chk(input int rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 1'b0; req_src = 1'b0; req_op = 2'b00;
    req_addr = '0; req_pc = '0; req_wdata = '0; flash_rdata = '0;
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    req_valid = 1'b1; req_src = v.src; req_op = v.op; req_addr = v.addr;
    req_pc = v.pc; req_wdata = v.wd; flash_rdata = v.fd;
    #1;
    chk(int'(v.req), "flash_re", 32'(flash_re), 32'(v.re));
    chk(int'(v.req), "flash_we", 32'(flash_we), 32'(v.we));
    chk(int'(v.req), "rd_denied", 32'(rd_denied), 32'(v.dn));
    chk(int'(v.req), "rd_data", 32'(rd_data), 32'(v.dat));
    @(posedge clk);
    #1;
    chk(int'(v.req), "wr_violation", 32'(wr_violation), 32'(v.vi));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nerr++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 outputs quiet in reset
    chk(9, "reset flash_re", 32'(flash_re), 0);
    chk(9, "reset flash_we", 32'(flash_we), 0);
    chk(9, "reset rd_denied", 32'(rd_denied), 0);
    chk(9, "reset rd_data", 32'(rd_data), 0);
    chk(9, "reset wr_violation", 32'(wr_violation), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int i = 0; i < NV; i++) apply(VT[i]);

    // R5 EEPROM bits follow the same clear-only rule
    apply(mk(0,WR,22'h300009,KB,8'h7F,8'h00,0,0,0,8'h00,0,5));
    apply(mk(0,RD,22'h300009,KB,8'h00,8'h00,0,0,0,8'h40,0,5));
    apply(mk(0,WR,22'h30000B,KB,8'h7F,8'h00,0,0,0,8'h00,0,5));
    apply(mk(0,RD,22'h30000B,KB,8'h00,8'h00,0,0,0,8'h60,0,5));
    // R2 pulse lasts one cycle only
    apply(mk(0,WR,22'h3FFFFF,KB,8'h00,8'h00,0,0,0,8'h00,1,2));
    @(negedge clk);
    idle();
    @(posedge clk);
    #1;
    chk(2, "pulse end", 32'(wr_violation), 0);

    // R9 reset mid-run restores the preload
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(9, "viol in reset", 32'(wr_violation), 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    apply(mk(0,RD,22'h300009,KB,8'h00,8'h00,0,0,0,8'hC0,0,9));
    apply(mk(0,RD,22'h30000B,KB,8'h00,8'h00,0,0,0,8'hE0,0,9));
    apply(mk(0,RD,22'h30000C,KB,8'h00,8'h00,0,0,0,8'h03,0,9));
    @(negedge clk);
    idle();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule